// File: doc/BRIEF.md
# CPU Execution Trace Recorder

The recorder sits beside a simple 32-bit pipelined processor and turns its architecturally visible activity into a stream of fixed-format trace records. It watches four sources: general register writes, writes to the four special registers (HI, LO, EPC, SR), data stores and data loads. It makes one record for each event that actually changes state or touches memory. Every record is tagged with the address of the instruction that caused it. A checker outside the block consumes the records over a valid/ready stream and compares them with a reference trace, so the records do not depend on pipeline stalls.

A register or special-register write that leaves the value unchanged produces no record. Instruction fetches and the program counter never produce records. Loads go to a synchronous memory, so a load record pairs the address presented in one cycle with the read data returned in the next cycle. Records raised in the same cycle enter an eight-deep queue in a fixed order. A sticky flag reports any record that found the queue full. A sticky halt flag rises when the processor fetches the same address twice in a row, or when a programmable cycle limit is reached.

Top module: `trace_recorder`

## Requirements
- R1: A general register write whose new value differs from its old value yields a record with kind 0, location = register index (zero-extended), mask 0, value = new value and the write's instruction address. A write whose old and new values are equal yields no record.
- R2: A special-register write whose value changes yields a record with kind 1 + selector, where selector 0 = HI, 1 = LO, 2 = EPC and 3 = SR. Location and mask are 0 and the value is the new value. An unchanged special write yields no record.
- R3: A store yields a record with kind 6, location = bus address, mask = {4'b0000, byte enables} and value = the full 32-bit bus data, including bytes that are not enabled. Mask bit 3 enables the lowest-addressed byte and bit 0 the highest.
- R4: A load presented in cycle n yields a record with kind 5, location = the cycle-n address, the cycle-n instruction address, mask 0 and value = the read data present in cycle n+1. Back-to-back loads each pair with their own data.
- R5: Records raised in the same cycle enter the queue in this order: completing load, store, register write, special write.
- R6: The queue holds up to 8 records and delivers them in first-in order. While the output is valid and not accepted, the output record stays unchanged.
- R7: A record raised while the queue has no free entry is dropped. The overflow output then goes high and stays high until reset. Records accepted before the drop are delivered intact.
- R8: Halt rises one cycle after a fetch whose address equals that of the previous fetch. Idle cycles between the two fetches do not matter. Halt stays high until reset.
- R9: With a nonzero timeout limit L, halt is low after L clock edges following reset release and high after L+1 edges. A limit of 0 disables the timeout.
- R10: Instruction fetches alone never produce a record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Instruction fetch this cycle |
| fetch_addr | input | 32 | Fetch address |
| rf_we | input | 1 | General register write |
| rf_idx | input | 5 | Register index written |
| rf_old | input | 32 | Value before the write |
| rf_new | input | 32 | Value written |
| rf_iaddr | input | 32 | Instruction address of the write |
| sp_we | input | 1 | Special-register write |
| sp_sel | input | 2 | 0 HI, 1 LO, 2 EPC, 3 SR |
| sp_old | input | 32 | Special value before the write |
| sp_new | input | 32 | Special value written |
| sp_iaddr | input | 32 | Instruction address of the special write |
| mem_rd | input | 1 | Word load presented this cycle |
| mem_wr | input | 1 | Store presented this cycle |
| mem_addr | input | 32 | Data bus address |
| mem_be | input | 4 | Store byte enables, bit 3 = lowest address |
| mem_wdata | input | 32 | Store data |
| mem_iaddr | input | 32 | Instruction address of the bus access |
| mem_rdata | input | 32 | Read data, one cycle after the load address |
| timeout_limit | input | TW | Cycle limit for halt, 0 disables |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer accepts the record |
| out_kind | output | 3 | Record kind |
| out_iaddr | output | 32 | Causing instruction address |
| out_loc | output | 32 | Register index or bus address |
| out_mask | output | 8 | Store byte mask |
| out_value | output | 32 | New value or bus data |
| overflow | output | 1 | Sticky: a record was dropped |
| halt | output | 1 | Sticky: repeat fetch or timeout |

## Verification
The hardest case to reach is a cycle that raises all four kinds of record at once: a load completing from the previous cycle, a store, a changed register write and a changed special write. It is also hard to fill the queue to the exact point where part of a cycle's records fit and the rest are dropped. The stimulus presents a load one cycle ahead, so its completion lines up with a store and both register writes. It then holds the consumer off while three-record cycles accumulate until the last special write finds the queue full. Back-to-back loads are swept so each load must pair with the data of the following cycle and not with its neighbour's.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int NSLOT = 4;  // load, store, register, special

  localparam logic [2:0] K_REG   = 3'd0;
  localparam logic [2:0] K_HI    = 3'd1;
  localparam logic [2:0] K_LOAD  = 3'd5;
  localparam logic [2:0] K_STORE = 3'd6;

  typedef struct packed {
    logic [2:0]  kind;
    logic [31:0] iaddr;
    logic [31:0] loc;
    logic [7:0]  mask;
    logic [31:0] value;
  } rec_t;

  function automatic rec_t mk_rec(logic [2:0] kind, logic [31:0] iaddr,
                                  logic [31:0] loc, logic [7:0] mask,
                                  logic [31:0] value);
    rec_t r;
    r.kind  = kind;
    r.iaddr = iaddr;
    r.loc   = loc;
    r.mask  = mask;
    r.value = value;
    return r;
  endfunction

  function automatic logic [7:0] be_to_mask(logic [3:0] be);
    return {4'b0000, be};
  endfunction

  function automatic logic [2:0] sp_kind(logic [1:0] sel);
    return K_HI + {1'b0, sel};
  endfunction
endpackage

// File: rtl/trc_events.sv
module trc_events
  import trc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rf_we,
  input  logic [4:0]             rf_idx,
  input  logic [31:0]            rf_old,
  input  logic [31:0]            rf_new,
  input  logic [31:0]            rf_iaddr,
  input  logic                   sp_we,
  input  logic [1:0]             sp_sel,
  input  logic [31:0]            sp_old,
  input  logic [31:0]            sp_new,
  input  logic [31:0]            sp_iaddr,
  input  logic                   mem_rd,
  input  logic                   mem_wr,
  input  logic [31:0]            mem_addr,
  input  logic [3:0]             mem_be,
  input  logic [31:0]            mem_wdata,
  input  logic [31:0]            mem_iaddr,
  input  logic [31:0]            mem_rdata,
  output logic [NSLOT-1:0]       slot_v,
  output rec_t [NSLOT-1:0]       slots,
  output logic                   ld_pend
);
  logic [31:0] ld_addr_q, ld_iaddr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_pend    <= 1'b0;
      ld_addr_q  <= '0;
      ld_iaddr_q <= '0;
    end else begin
      ld_pend <= mem_rd;
      if (mem_rd) begin
        ld_addr_q  <= mem_addr;
        ld_iaddr_q <= mem_iaddr;
      end
    end
  end

  always_comb begin
    slot_v[0] = ld_pend;
    slots[0]  = mk_rec(K_LOAD, ld_iaddr_q, ld_addr_q, 8'h00, mem_rdata);
    slot_v[1] = mem_wr;
    slots[1]  = mk_rec(K_STORE, mem_iaddr, mem_addr, be_to_mask(mem_be), mem_wdata);
    slot_v[2] = rf_we && (rf_new != rf_old);
    slots[2]  = mk_rec(K_REG, rf_iaddr, {27'd0, rf_idx}, 8'h00, rf_new);
    slot_v[3] = sp_we && (sp_new != sp_old);
    slots[3]  = mk_rec(sp_kind(sp_sel), sp_iaddr, 32'd0, 8'h00, sp_new);
  end
endmodule

// File: rtl/trc_fifo.sv
module trc_fifo
  import trc_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSLOT-1:0]   slot_v,
  input  rec_t [NSLOT-1:0]   slots,
  input  logic               pop,
  output rec_t               head,
  output logic               nonempty,
  output logic [$clog2(DEPTH):0] fill,
  output logic               drop,
  output logic               ovf
);
  localparam int AW = $clog2(DEPTH);

  rec_t             mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      cnt_q;
  logic [NSLOT-1:0] acc;
  logic [AW-1:0]    offs [NSLOT];
  int               n_acc;

  always_comb begin
    int run;
    run = 0;
    for (int i = 0; i < NSLOT; i++) begin
      offs[i] = AW'(run);
      acc[i]  = slot_v[i] && (int'(cnt_q) + run < DEPTH);
      run     = run + int'(slot_v[i]);
    end
    n_acc = $countones(acc);
    drop  = |(slot_v & ~acc);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
      ovf    <= 1'b0;
    end else begin
      for (int i = 0; i < NSLOT; i++)
        if (acc[i]) mem[AW'(wr_ptr + offs[i])] <= slots[i];
      wr_ptr <= AW'(wr_ptr + AW'(n_acc));
      if (pop) rd_ptr <= AW'(rd_ptr + 1'b1);
      cnt_q  <= cnt_q + (AW+1)'(n_acc) - (AW+1)'(pop);
      if (drop) ovf <= 1'b1;
    end
  end

  assign nonempty = (cnt_q != '0);
  assign head     = mem[rd_ptr];
  assign fill     = cnt_q;
endmodule

// File: rtl/trc_halt.sv
module trc_halt #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [31:0]   fetch_addr,
  input  logic [TW-1:0] limit,
  output logic          repeat_hit,
  output logic          timeout_hit,
  output logic          halt
);
  logic          prev_v;
  logic [31:0]   prev_a;
  logic [TW-1:0] cyc_q;

  assign repeat_hit  = fetch_valid && prev_v && (fetch_addr == prev_a);
  assign timeout_hit = (limit != '0) && (cyc_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_v <= 1'b0;
      prev_a <= '0;
      cyc_q  <= '0;
      halt   <= 1'b0;
    end else begin
      if (fetch_valid) begin
        prev_v <= 1'b1;
        prev_a <= fetch_addr;
      end
      if (cyc_q != '1) cyc_q <= cyc_q + 1'b1;
      if (repeat_hit || timeout_hit) halt <= 1'b1;
    end
  end
endmodule

// File: rtl/trace_recorder.sv
module trace_recorder
  import trc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [31:0]   fetch_addr,
  input  logic          rf_we,
  input  logic [4:0]    rf_idx,
  input  logic [31:0]   rf_old,
  input  logic [31:0]   rf_new,
  input  logic [31:0]   rf_iaddr,
  input  logic          sp_we,
  input  logic [1:0]    sp_sel,
  input  logic [31:0]   sp_old,
  input  logic [31:0]   sp_new,
  input  logic [31:0]   sp_iaddr,
  input  logic          mem_rd,
  input  logic          mem_wr,
  input  logic [31:0]   mem_addr,
  input  logic [3:0]    mem_be,
  input  logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_iaddr,
  input  logic [31:0]   mem_rdata,
  input  logic [TW-1:0] timeout_limit,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2:0]    out_kind,
  output logic [31:0]   out_iaddr,
  output logic [31:0]   out_loc,
  output logic [7:0]    out_mask,
  output logic [31:0]   out_value,
  output logic          overflow,
  output logic          halt
);
  localparam int FW = $clog2(DEPTH) + 1;

  logic [NSLOT-1:0] slot_v;
  rec_t [NSLOT-1:0] slots;
  logic             ld_pend;
  rec_t             head;
  logic [FW-1:0]    fill;
  logic             drop;
  logic             pop;
  logic             repeat_hit, timeout_hit;

  trc_events u_events (
    .clk, .rst_n,
    .rf_we, .rf_idx, .rf_old, .rf_new, .rf_iaddr,
    .sp_we, .sp_sel, .sp_old, .sp_new, .sp_iaddr,
    .mem_rd, .mem_wr, .mem_addr, .mem_be, .mem_wdata, .mem_iaddr, .mem_rdata,
    .slot_v, .slots, .ld_pend
  );

  assign pop = out_valid && out_ready;

  trc_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk, .rst_n, .slot_v, .slots, .pop,
    .head, .nonempty(out_valid), .fill, .drop, .ovf(overflow)
  );

  trc_halt #(.TW(TW)) u_halt (
    .clk, .rst_n, .fetch_valid, .fetch_addr, .limit(timeout_limit),
    .repeat_hit, .timeout_hit, .halt
  );

  assign out_kind  = head.kind;
  assign out_iaddr = head.iaddr;
  assign out_loc   = head.loc;
  assign out_mask  = head.mask;
  assign out_value = head.value;
endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
  parameter int DEPTH = 8,
  parameter int FW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          ld_pend,
  input logic          drop,
  input logic          repeat_hit,
  input logic [FW-1:0] fill,
  input logic          out_valid,
  input logic          out_ready,
  input logic [2:0]    out_kind,
  input logic [31:0]   out_value,
  input logic [31:0]   out_loc,
  input logic [7:0]    out_mask,
  input logic          overflow,
  input logic          halt
);
  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);
  assert_repeat_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    repeat_hit |=> halt);
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_drop_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overflow);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) &&
      $stable(out_value) && $stable(out_loc) && $stable(out_mask)));
  assert_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= DEPTH);
  assert_mask_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask[7:4] == 4'h0));
  assert_load_pairs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> ld_pend);
endmodule

bind trace_recorder trc_checker #(.DEPTH(DEPTH), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .ld_pend(ld_pend),
  .drop(drop), .repeat_hit(repeat_hit), .fill(fill),
  .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
  .out_value(out_value), .out_loc(out_loc), .out_mask(out_mask),
  .overflow(overflow), .halt(halt)
);

// File: tb/test_trace_recorder.sv
module test_trace_recorder;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid;
  logic [31:0] fetch_addr;
  logic        rf_we;
  logic [4:0]  rf_idx;
  logic [31:0] rf_old, rf_new, rf_iaddr;
  logic        sp_we;
  logic [1:0]  sp_sel;
  logic [31:0] sp_old, sp_new, sp_iaddr;
  logic        mem_rd, mem_wr;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_iaddr, mem_rdata;
  logic [31:0] timeout_limit;
  logic        out_valid, out_ready;
  logic [2:0]  out_kind;
  logic [31:0] out_iaddr, out_loc, out_value;
  logic [7:0]  out_mask;
  logic        overflow, halt;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic [106:0] expq [$];

  always #(PERIOD/2) clk = ~clk;

  trace_recorder i_trace_recorder (
    .clk, .rst_n, .fetch_valid, .fetch_addr,
    .rf_we, .rf_idx, .rf_old, .rf_new, .rf_iaddr,
    .sp_we, .sp_sel, .sp_old, .sp_new, .sp_iaddr,
    .mem_rd, .mem_wr, .mem_addr, .mem_be, .mem_wdata, .mem_iaddr, .mem_rdata,
    .timeout_limit, .out_valid, .out_ready, .out_kind, .out_iaddr,
    .out_loc, .out_mask, .out_value, .overflow, .halt
  );

  function automatic logic [106:0] rec(logic [2:0] k, logic [31:0] ia,
                                       logic [31:0] loc, logic [7:0] m,
                                       logic [31:0] v);
    return {k, ia, loc, m, v};
  endfunction

  task automatic chk(bit ok, string req, logic [107:0] act, logic [107:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    fetch_valid = 0; fetch_addr = 0;
    rf_we = 0; rf_idx = 0; rf_old = 0; rf_new = 0; rf_iaddr = 0;
    sp_we = 0; sp_sel = 0; sp_old = 0; sp_new = 0; sp_iaddr = 0;
    mem_rd = 0; mem_wr = 0; mem_addr = 0; mem_be = 0; mem_wdata = 0;
    mem_iaddr = 0; mem_rdata = 32'hDEAD_BEEF;
  endtask

  task automatic do_reset(logic [31:0] lim);
    idle();
    out_ready = 0;
    timeout_limit = lim;
    rst_n = 0;
    step(); step();
    rst_n = 1;
  endtask

  task automatic drain(string req);
    out_ready = 1;
    while (expq.size() > 0) begin
      logic [106:0] e;
      logic [106:0] a;
      e = expq.pop_front();
      a = {out_kind, out_iaddr, out_loc, out_mask, out_value};
      chk(out_valid && a == e, req, {out_valid, a}, {1'b1, e});
      step();
    end
    out_ready = 0;
    chk(out_valid == 1'b0, req, {107'd0, out_valid}, 108'd0);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    do_reset(0);
    @(negedge clk);
    // reset state
    chk(out_valid == 0 && overflow == 0 && halt == 0, "R6 reset",
        {105'd0, out_valid, overflow, halt}, 108'd0);

    // R1: all register indices, changed and unchanged writes
    for (int b = 0; b < 4; b++) begin
      for (int j = 0; j < 8; j++) begin
        int idx;
        idx = b * 8 + j;
        rf_we = 1; rf_idx = 5'(idx);
        rf_old = 32'(idx * 3); rf_new = 32'(idx * 3 + idx + 1);
        rf_iaddr = 32'h8000_0000 + 32'(idx * 4);
        step();
        expq.push_back(rec(3'd0, 32'h8000_0000 + 32'(idx * 4), 32'(idx), 8'h00,
                           32'(idx * 3 + idx + 1)));
        rf_new = rf_old;  // unchanged write: no record (R1)
        step();
      end
      idle();
      drain("R1");
    end

    // R2: each special register, changed then unchanged
    for (int s = 0; s < 4; s++) begin
      sp_we = 1; sp_sel = 2'(s);
      sp_old = 32'h100 + 32'(s); sp_new = 32'h5A00 + 32'(s);
      sp_iaddr = 32'h9000_0000 + 32'(s);
      step();
      expq.push_back(rec(3'(1 + s), 32'h9000_0000 + 32'(s), 0, 8'h00, 32'h5A00 + 32'(s)));
      sp_new = sp_old;
      step();
    end
    idle();
    drain("R2");

    // R3: every byte-enable pattern
    for (int b = 0; b < 2; b++) begin
      for (int j = 0; j < 8; j++) begin
        int be;
        be = b * 8 + j;
        mem_wr = 1; mem_be = 4'(be);
        mem_addr = 32'h2000_0000 + 32'(be * 4);
        mem_wdata = 32'h0102_0304 * 32'(be + 1);
        mem_iaddr = 32'hA000_0000 + 32'(be);
        step();
        expq.push_back(rec(3'd6, 32'hA000_0000 + 32'(be), 32'h2000_0000 + 32'(be * 4),
                           8'(be), 32'h0102_0304 * 32'(be + 1)));
      end
      idle();
      drain("R3");
    end

    // R4: eight back-to-back loads, data one cycle late
    for (int i = 0; i <= 8; i++) begin
      mem_rd = (i < 8);
      mem_addr = 32'h3000_0000 + 32'(i * 16);
      mem_iaddr = 32'hB000_0000 + 32'(i * 4);
      mem_rdata = (i > 0) ? 32'hC0DE_0000 + 32'(i - 1) : 32'hFFFF_FFFF;
      step();
      if (i > 0)
        expq.push_back(rec(3'd5, 32'hB000_0000 + 32'((i - 1) * 4),
                           32'h3000_0000 + 32'((i - 1) * 16), 8'h00, 32'hC0DE_0000 + 32'(i - 1)));
    end
    idle();
    drain("R4");

    // R5: load completion, store, register and special in one cycle
    mem_rd = 1; mem_addr = 32'h4444_0000; mem_iaddr = 32'h0000_0100;
    step();
    idle();
    mem_rdata = 32'h1234_5678;
    mem_wr = 1; mem_addr = 32'h5555_0000; mem_be = 4'b1000; mem_wdata = 32'hAABB_CCDD;
    mem_iaddr = 32'h0000_0104;
    rf_we = 1; rf_idx = 5'd3; rf_old = 0; rf_new = 32'h1234_5678; rf_iaddr = 32'h0000_0100;
    sp_we = 1; sp_sel = 2'd2; sp_old = 0; sp_new = 32'h0000_0108; sp_iaddr = 32'h0000_0108;
    step();
    idle();
    expq.push_back(rec(3'd5, 32'h0000_0100, 32'h4444_0000, 8'h00, 32'h1234_5678));
    expq.push_back(rec(3'd6, 32'h0000_0104, 32'h5555_0000, 8'h08, 32'hAABB_CCDD));
    expq.push_back(rec(3'd0, 32'h0000_0100, 32'd3, 8'h00, 32'h1234_5678));
    expq.push_back(rec(3'd3, 32'h0000_0108, 32'd0, 8'h00, 32'h0000_0108));
    // R6: stalled output holds
    begin
      logic [106:0] a0;
      a0 = {out_kind, out_iaddr, out_loc, out_mask, out_value};
      step();
      chk(out_valid && a0 == {out_kind, out_iaddr, out_loc, out_mask, out_value},
          "R6 hold", {out_valid, out_kind, out_iaddr, out_loc, out_mask, out_value},
          {1'b1, a0});
    end
    drain("R5");

    // R7: three cycles of three records each; the ninth is dropped
    chk(overflow == 0, "R7 pre", {107'd0, overflow}, 108'd0);
    for (int c = 0; c < 3; c++) begin
      mem_wr = 1; mem_addr = 32'h6000_0000 + 32'(c); mem_be = 4'hF;
      mem_wdata = 32'(c); mem_iaddr = 32'h10 + 32'(c);
      rf_we = 1; rf_idx = 5'(c + 1); rf_old = 0; rf_new = 32'h70 + 32'(c);
      rf_iaddr = 32'h20 + 32'(c);
      sp_we = 1; sp_sel = 2'd0; sp_old = 0; sp_new = 32'h80 + 32'(c);
      sp_iaddr = 32'h30 + 32'(c);
      step();
      expq.push_back(rec(3'd6, 32'h10 + 32'(c), 32'h6000_0000 + 32'(c), 8'h0F, 32'(c)));
      expq.push_back(rec(3'd0, 32'h20 + 32'(c), 32'(c + 1), 8'h00, 32'h70 + 32'(c)));
      if (c < 2)
        expq.push_back(rec(3'd1, 32'h30 + 32'(c), 32'd0, 8'h00, 32'h80 + 32'(c)));
    end
    idle();
    chk(overflow == 1, "R7 set", {107'd0, overflow}, 108'd1);
    drain("R7");
    step();
    chk(overflow == 1, "R7 sticky", {107'd0, overflow}, 108'd1);

    // R8 / R10: repeat fetch detection
    do_reset(0);
    fetch_valid = 1; fetch_addr = 32'hBFC0_0000; step();
    fetch_valid = 0; step();
    fetch_valid = 1; fetch_addr = 32'hBFC0_0004; step();
    fetch_valid = 1; fetch_addr = 32'hBFC0_0000; step();
    fetch_valid = 0; step();
    chk(halt == 0, "R8 distinct", {107'd0, halt}, 108'd0);
    chk(out_valid == 0, "R10 no record", {107'd0, out_valid}, 108'd0);
    fetch_valid = 1; fetch_addr = 32'hBFC0_0000; step();
    fetch_valid = 0;
    chk(halt == 1, "R8 repeat", {107'd0, halt}, 108'd1);
    repeat (3) step();
    chk(halt == 1, "R8 sticky", {107'd0, halt}, 108'd1);
    chk(out_valid == 0, "R10 no record", {107'd0, out_valid}, 108'd0);

    // R9: timeout
    do_reset(32'd20);
    repeat (20) step();
    chk(halt == 0, "R9 before", {107'd0, halt}, 108'd0);
    step();
    chk(halt == 1, "R9 at limit", {107'd0, halt}, 108'd1);
    do_reset(32'd0);
    repeat (60) step();
    chk(halt == 0, "R9 disabled", {107'd0, halt}, 108'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule